// File: doc/BRIEF.md
# Hexagonal Cluster Neighbour Trigger

This block is a synchronous topological trigger for a 49-pixel camera region. The region is built from seven hexagonal clusters of seven pixels each: a central cluster and the six clusters that ring it. On every clock the block takes one discriminator bit per pixel. It decides whether any three fired pixels form a connected group on the hexagonal grid, where a chain and a closed triangle both qualify. Each sample is judged on its own.

The result goes out as a 4-bit trigger code. The code reports a hit anywhere in the region and a hit pivoted in the central cluster. It also reports whether any neighbouring region signalled a trigger in the same sample, and whether that coincided with a local hit. The central-cluster decision is copied onto six single-cycle trigger lines, one for each neighbouring region.

Links between pixels of different clusters come from a constant table parameter. Regions tiled across a camera overlap by one cluster.

Top module: `hex_cluster_trigger`

## Requirements
- R1: While `rst` is high at a clock edge, `trig_code` and `trig_out` read zero after that edge.
- R2: Pixel and neighbour bits present before clock edge N determine the outputs after edge N+1, so latency is two cycles. Each sample is evaluated independently of the samples before and after it.
- R3: A sample with fewer than three active pixels never sets `trig_code[0]`, and neither does a pair of adjacent pixels.
- R4: Inside a cluster, pixel 0 is adjacent to pixels 1 through 6. Ring pixel i (1..6) is also adjacent to ring pixels i-1 and i+1, wrapping so that 6 and 1 touch. `trig_code[0]` is set when some active pixel has at least two active neighbours, so a chain or a triangle of three sets it. Ring pixels 1, 3 and 5 alone do not set it.
- R5: With the default table, for k in 1..6 and d = k-1, these pairs are also adjacent: centre-cluster pixel d+1 with cluster k pixel ((d+3) mod 6)+1, and cluster k pixel ((d+2) mod 6)+1 with cluster (k mod 6)+1 pixel ((d+5) mod 6)+1. A triple joined only through such a link triggers. Pixels that are not joined by any rule do not.
- R6: `trig_code[1]` is set when a centre-cluster pixel is active and has at least two active neighbours in any cluster. All six `trig_out` bits equal `trig_code[1]` in every cycle, so they stay high one cycle per qualifying sample.
- R7: `trig_code[2]` is the OR of the six `trig_in` bits, with the same two-cycle latency as the pixel path.
- R8: `trig_code[3]` is set exactly when `trig_code[0]` and `trig_code[2]` are both set.
- R9: Pixel p (0..6) of cluster g (0 = centre, 1..6 = ring clusters) is `pix_in[7*g+p]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trigger clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 49 | Discriminator bit per pixel, indexed 7*cluster+pixel |
| trig_in | input | 6 | Trigger lines from the six neighbouring regions |
| trig_code | output | 4 | {coincidence, neighbour any, centre hit, region hit} |
| trig_out | output | 6 | Centre-cluster trigger sent to each neighbouring region |

## Verification
The assertions assume that pixel and neighbour bits are synchronous to `clk` and stable around its rising edge. They also assume that reset is held for at least one edge before checking starts. The bench meets this by changing inputs only on the falling edge and holding reset for several cycles.

The count-based checks rely on a hit needing three active pixels whatever the link table holds. The stimulus therefore mixes sparse random patterns with hand-placed chains, triangles, wrap-around rings and link-crossing triples, so that both the firing and the non-firing side of each rule are reached.

// File: rtl/hex_trig_pkg.sv
package hex_trig_pkg;
  localparam int GRP_N   = 7;
  localparam int PIX_N   = 7;
  localparam int RING_N  = 6;
  localparam int PIX_TOT = GRP_N * PIX_N;
  localparam int IDX_W   = $clog2(PIX_TOT);
  localparam int LINK_N  = 2 * RING_N;
  localparam int CODE_W  = 4;
  localparam int MIN_NB  = 2;

  typedef struct packed {
    logic [IDX_W-1:0] a;
    logic [IDX_W-1:0] b;
  } link_t;

  typedef link_t [LINK_N-1:0] link_tab_t;
  typedef logic [PIX_TOT-1:0][PIX_TOT-1:0] adj_mat_t;

  // Default inter-cluster links: centre to each ring cluster, and ring cluster to the next one.
  function automatic link_tab_t default_links();
    link_tab_t t;
    int d;
    for (int k = 1; k <= RING_N; k++) begin
      d = k - 1;
      t[2*d].a   = IDX_W'(d + 1);
      t[2*d].b   = IDX_W'(k * PIX_N + (d + 3) % RING_N + 1);
      t[2*d+1].a = IDX_W'(k * PIX_N + (d + 2) % RING_N + 1);
      t[2*d+1].b = IDX_W'((k % RING_N + 1) * PIX_N + (d + 5) % RING_N + 1);
    end
    return t;
  endfunction

  // Symmetric adjacency matrix: hexagon inside each cluster plus table links.
  function automatic adj_mat_t build_adj(link_tab_t links);
    adj_mat_t m;
    int c;
    int nx;
    int a;
    int b;
    m = '0;
    for (int g = 0; g < GRP_N; g++) begin
      c = g * PIX_N;
      for (int i = 1; i <= RING_N; i++) begin
        nx = i % RING_N + 1;
        m[c][c+i]     = 1'b1;
        m[c+i][c]     = 1'b1;
        m[c+i][c+nx]  = 1'b1;
        m[c+nx][c+i]  = 1'b1;
      end
    end
    for (int l = 0; l < LINK_N; l++) begin
      a = int'(links[l].a);
      b = int'(links[l].b);
      m[a][b] = 1'b1;
      m[b][a] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/hex_pipe.sv
module hex_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH+1];

  assign stg[0] = d;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s+1] <= '0;
      else     stg[s+1] <= stg[s];
    end
  end

  assign q = stg[DEPTH];
endmodule

// File: rtl/hex_adj_core.sv
module hex_adj_core
  import hex_trig_pkg::*;
#(
  parameter adj_mat_t ADJ = build_adj(default_links())
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PIX_TOT-1:0] act,
  output logic               any_hit,
  output logic               ctr_hit
);
  logic [PIX_TOT-1:0] hit;

  // A pixel pivots a connected triple when it and two of its neighbours are active.
  for (genvar p = 0; p < PIX_TOT; p++) begin : g_pix
    logic [PIX_TOT-1:0] nb_act;
    assign nb_act = act & ADJ[p];
    assign hit[p] = act[p] && ($countones(nb_act) >= MIN_NB);
  end

  assign any_hit = |hit;
  assign ctr_hit = |hit[PIX_N-1:0];

  assert_min_three_R3: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> ($countones(act) >= 3));

  assert_centre_in_region_R6: assert property (@(posedge clk) disable iff (rst)
    ctr_hit |-> any_hit);

  assert_centre_needs_centre_pixel_R6: assert property (@(posedge clk) disable iff (rst)
    ctr_hit |-> (act[PIX_N-1:0] != '0));
endmodule

// File: rtl/hex_trig_out.sv
module hex_trig_out
  import hex_trig_pkg::*;
#(
  parameter int NB_N = RING_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any_hit,
  input  logic              ctr_hit,
  input  logic              nb_any,
  output logic [CODE_W-1:0] trig_code,
  output logic [NB_N-1:0]   trig_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      trig_code <= '0;
      trig_out  <= '0;
    end else begin
      trig_code <= {any_hit & nb_any, nb_any, ctr_hit, any_hit};
      trig_out  <= {NB_N{ctr_hit}};
    end
  end

  assert_lines_uniform_R6: assert property (@(posedge clk) disable iff (rst)
    (trig_out != '0) |-> (trig_out == '1));
endmodule

// File: rtl/hex_cluster_trigger.sv
module hex_cluster_trigger
  import hex_trig_pkg::*;
#(
  parameter link_tab_t LINKS = default_links(),
  parameter int        NB_N  = RING_N
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PIX_TOT-1:0] pix_in,
  input  logic [NB_N-1:0]    trig_in,
  output logic [CODE_W-1:0]  trig_code,
  output logic [NB_N-1:0]    trig_out
);
  localparam adj_mat_t ADJ = build_adj(LINKS);

  logic [PIX_TOT-1:0] pix_q;
  logic [NB_N-1:0]    nb_q;
  logic               any_hit;
  logic               ctr_hit;

  hex_pipe #(.W(PIX_TOT), .DEPTH(1)) u_pix_pipe (
    .clk(clk), .rst(rst), .d(pix_in), .q(pix_q)
  );

  hex_pipe #(.W(NB_N), .DEPTH(1)) u_nb_pipe (
    .clk(clk), .rst(rst), .d(trig_in), .q(nb_q)
  );

  hex_adj_core #(.ADJ(ADJ)) u_core (
    .clk(clk), .rst(rst), .act(pix_q), .any_hit(any_hit), .ctr_hit(ctr_hit)
  );

  hex_trig_out #(.NB_N(NB_N)) u_out (
    .clk(clk), .rst(rst), .any_hit(any_hit), .ctr_hit(ctr_hit),
    .nb_any(|nb_q), .trig_code(trig_code), .trig_out(trig_out)
  );

  assert_centre_implies_region_R6: assert property (@(posedge clk) disable iff (rst)
    trig_code[1] |-> trig_code[0]);

  assert_coincidence_R8: assert property (@(posedge clk) disable iff (rst)
    trig_code[3] |-> (trig_code[0] && trig_code[2]));

  assert_out_follows_centre_R6: assert property (@(posedge clk) disable iff (rst)
    (trig_out[0] == trig_code[1]));
endmodule

// File: tb/hex_cluster_trigger_bench.sv
module hex_cluster_trigger_bench;
  localparam int NP = 49;
  localparam int NB = 6;

  typedef struct {
    logic [3:0] code;
    logic [5:0] outs;
    string      tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pix_in = '0;
  logic [NB-1:0] trig_in = '0;
  logic [3:0]    trig_code;
  logic [NB-1:0] trig_out;

  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  exp_t q[$];
  logic [NP-1:0] adj [NP];

  always #4ns clk = ~clk;

  hex_cluster_trigger u_hex_cluster_trigger (
    .clk(clk), .rst(rst), .pix_in(pix_in), .trig_in(trig_in),
    .trig_code(trig_code), .trig_out(trig_out)
  );

  function automatic int px(int g, int p);
    return 7 * g + p;  // R9 index layout
  endfunction

  task automatic link(int a, int b);
    adj[a][b] = 1'b1;
    adj[b][a] = 1'b1;
  endtask

  task automatic build_model();
    for (int p = 0; p < NP; p++) adj[p] = '0;
    for (int g = 0; g < 7; g++)
      for (int i = 1; i <= 6; i++) begin
        link(px(g, 0), px(g, i));                // R4 centre to ring
        link(px(g, i), px(g, (i % 6) + 1));      // R4 ring neighbours
      end
    for (int k = 1; k <= 6; k++) begin
      link(px(0, k), px(k, ((k + 2) % 6) + 1));               // R5 centre link
      link(px(k, ((k + 1) % 6) + 1), px((k % 6) + 1, ((k + 4) % 6) + 1)); // R5 ring link
    end
  endtask

  function automatic exp_t model(logic [NP-1:0] v, logic [NB-1:0] ti, string tag);
    exp_t e;
    logic anyh = 1'b0;
    logic ctr  = 1'b0;
    logic nb   = |ti;
    for (int p = 0; p < NP; p++) begin
      if (v[p] && $countones(v & adj[p]) >= 2) begin
        anyh = 1'b1;
        if (p < 7) ctr = 1'b1;
      end
    end
    e.code = {anyh & nb, nb, ctr, anyh};
    e.outs = {6{ctr}};
    e.tag  = tag;
    return e;
  endfunction

  task automatic check(logic [9:0] act, logic [9:0] expv, string tag);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got code=%b out=%b, expected code=%b out=%b",
               tag, act[3:0], act[9:4], expv[3:0], expv[9:4]);
    end
  endtask

  // Driver: one sample per cycle; the monitor side pops the result due two cycles back (R2).
  task automatic apply(logic [NP-1:0] v, logic [NB-1:0] ti, string tag);
    exp_t e;
    @(negedge clk);
    if (q.size() >= 2) begin
      e = q.pop_front();
      check({trig_out, trig_code}, {e.outs, e.code}, e.tag);
    end
    pix_in  = v;
    trig_in = ti;
    q.push_back(model(v, ti, tag));
  endtask

  function automatic logic [NP-1:0] set3(int a, int b, int c);
    logic [NP-1:0] v = '0;
    v[a] = 1'b1;
    v[b] = 1'b1;
    v[c] = 1'b1;
    return v;
  endfunction

  initial begin
    logic [NP-1:0] v;
    build_model();
    pix_in  = '1;
    trig_in = '1;
    repeat (4) @(negedge clk);
    check({trig_out, trig_code}, 10'd0, "R1 reset state");
    pix_in  = '0;
    trig_in = '0;
    rst     = 1'b0;

    apply('0, '0, "R3 idle");
    v = '0; v[px(0, 0)] = 1'b1; v[px(0, 1)] = 1'b1;
    apply(v, '0, "R3 adjacent pair");
    apply(set3(px(0, 1), px(0, 0), px(0, 4)), '0, "R4 R6 centre chain");
    apply(set3(px(3, 0), px(3, 1), px(3, 2)), '0, "R4 triangle ring cluster");
    apply(set3(px(2, 1), px(2, 3), px(2, 5)), '0, "R4 alternate ring none");
    apply(set3(px(5, 6), px(5, 1), px(5, 2)), '0, "R4 ring wrap chain");
    apply(set3(px(0, 1), px(1, 4), px(1, 0)), '0, "R5 link pivot outside");
    apply(set3(px(0, 0), px(0, 1), px(1, 4)), '0, "R5 R6 link pivot centre");
    apply(set3(px(0, 1), px(2, 4), px(2, 0)), '0, "R5 unlinked none");
    apply(set3(px(1, 3), px(2, 6), px(2, 0)), '0, "R5 ring to ring link");
    apply('0, 6'b000100, "R7 neighbour only");
    apply(set3(px(4, 0), px(4, 3), px(4, 4)), 6'b100000, "R8 coincidence");
    apply(set3(px(0, 2), px(0, 3), px(0, 0)), 6'b000001, "R8 centre coincidence");
    for (int i = 0; i < 6; i++) begin
      apply(set3(px(0, 0), px(0, 5), px(0, 6)), '0, "R6 single cycle on");
      apply('0, '0, "R6 single cycle off");
    end
    for (int i = 0; i < 400; i++) begin
      v = '0;
      for (int b = 0; b < NP; b++) v[b] = ($urandom_range(0, 11) == 0);
      apply(v, NB'($urandom_range(0, 3) == 0 ? $urandom_range(1, 63) : 0), "R2 random sample");
    end
    apply('0, '0, "R2 flush");
    apply('0, '0, "R2 flush");
    apply('0, '0, "R2 flush");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8ns);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule